// File: doc/BRIEF.md
# Periodic Framed SPI Command Sequencer

This block is an SPI master that plays out a burst of 16-bit command words held in a local word buffer toward an analog-to-digital converter. Each word travels in its own frame: chip-select drops, sixteen bits go out most significant bit first, and chip-select rises again. The converter starts a conversion on the falling chip-select edge. For that reason the frames are launched by a period timer and not by the end of the previous transfer. The spacing between falling chip-select edges is exact and does not depend on software.

Software fills the buffer through a simple write port. It then sets the word count, the frame period in system clocks and the serial clock divider, and pulses `start`. The block latches these settings, raises `busy`, and sends words from buffer address 0 upward. `done` pulses once after the last frame. The serial clock uses SPI mode 0: it idles low, data is sampled on its rising edge, and data changes while it is low. If the requested period cannot hold a whole frame plus a minimum chip-select high gap, the block lengthens the period to that minimum and raises `period_err`.

Top module: `burst_cmd_spi`

## Requirements
- R1: Each frame carries one 16-bit word, most significant bit first. SCLK idles low. MOSI changes only while SCLK is low, so it is stable for every rising SCLK edge.
- R2: Each SCLK low phase and each high phase lasts H system clocks, where H is `clk_div` and a value of 0 counts as 1. Within a frame, rising edge b (counting from 0) comes (2b+1)·H clocks after `cs_n` falls, and `cs_n` stays low for exactly 32·H clocks.
- R3: `cs_n` is low during one frame per word and high between frames and when idle. SCLK is low whenever `cs_n` is high.
- R4: The first frame's `cs_n` falls in the cycle after the clock edge that accepts `start`. Each later frame's `cs_n` falls exactly P clocks after the previous fall, where P is the effective period.
- R5: If `period` is less than 32·H+2, then P is 32·H+2 and `period_err` is high. Otherwise P equals `period` and `period_err` is low. `period_err` takes its value in the cycle after an accepted start and holds it until the next accepted start.
- R6: A burst sends N frames with words from buffer addresses 0 to N-1 in order. N is `word_count`, clamped to the buffer depth of 256. A start with `word_count` 0 is ignored.
- R7: `busy` is high from the cycle after an accepted start until the cycle in which `cs_n` rises after the last frame. In that cycle `busy` is low and `done` is high, for that single cycle only.
- R8: A `start` pulse while `busy` is high is ignored, together with any new count, period or divider values. The running burst keeps its frame count and timing.
- R9: After reset, `cs_n` is 1 and `sclk`, `mosi`, `busy`, `done` and `period_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Buffer write strobe |
| wr_addr | input | 8 | Buffer write address |
| wr_data | input | 16 | Command word to store |
| start | input | 1 | Burst launch request (one cycle) |
| word_count | input | 9 | Number of words in the burst |
| period | input | 16 | Frame-to-frame period in system clocks |
| clk_div | input | 8 | SCLK half-period in system clocks (0 treated as 1) |
| sclk | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Active-low chip-select, one pulse per word |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle end-of-burst pulse |
| period_err | output | 1 | Requested period was too short and was stretched |

## Verification
All results are timed from the clock edge that accepts `start`. The first `cs_n` fall, `busy` and `period_err` are all due one cycle later. Bit b rises (2b+1)·H cycles after its frame's fall, and the frame ends 32·H cycles after it. The next fall is due P cycles after the previous one, and `done` is due (N-1)·P+32·H cycles after the first fall. The bench counts cycles at the falling clock edge from that first fall and compares each observed edge against these sums, computed from the requirements.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    typedef int unsigned u32_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FRAME,
        ST_GAP
    } seq_state_e;

    localparam u32_t HALVES_PER_BIT = 2;

    function automatic u32_t half_len(u32_t div);
        return (div == 0) ? 1 : div;
    endfunction

    function automatic u32_t min_period(u32_t div, u32_t word_w, u32_t gap);
        return half_len(div) * HALVES_PER_BIT * word_w + gap;
    endfunction

endpackage

// File: rtl/bcs_word_buf.sv
module bcs_word_buf #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned DEPTH  = 256,
    localparam int unsigned AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data
);

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/bcs_period_timer.sv
module bcs_period_timer #(
    parameter int unsigned PER_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [PER_W-1:0] span,
    output logic             due,
    output logic [PER_W-1:0] elapsed
);

    logic [PER_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign due     = run && (cnt_q == span - 1'b1);
    assign elapsed = cnt_q;

    // R4
    period_bound_chk: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt_q < span));

endmodule

// File: rtl/bcs_bit_shifter.sv
module bcs_bit_shifter #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned DIV_W  = 8,
    localparam int unsigned HALVES = 2 * WORD_W,
    localparam int unsigned HB_W   = $clog2(HALVES),
    localparam int unsigned HB_END = HALVES - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    input  logic [DIV_W-1:0]  half,
    output logic              sclk,
    output logic              mosi,
    output logic              frame_end
);

    logic              run_q;
    logic [DIV_W-1:0]  ph_q;
    logic [HB_W-1:0]   hb_q;
    logic [WORD_W-1:0] sh_q;
    logic              half_end;

    assign half_end  = run_q && (ph_q == half - 1'b1);
    assign frame_end = half_end && (hb_q == HB_W'(HB_END));

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            ph_q  <= '0;
            hb_q  <= '0;
            sh_q  <= '0;
        end else if (load) begin
            run_q <= 1'b1;
            ph_q  <= '0;
            hb_q  <= '0;
            sh_q  <= word;
        end else if (run_q) begin
            if (half_end) begin
                ph_q <= '0;
                if (frame_end) begin
                    run_q <= 1'b0;
                    hb_q  <= '0;
                    sh_q  <= '0;
                end else begin
                    hb_q <= hb_q + 1'b1;
                    if (hb_q[0]) begin
                        sh_q <= sh_q << 1;
                    end
                end
            end else begin
                ph_q <= ph_q + 1'b1;
            end
        end
    end

    assign sclk = hb_q[0];
    assign mosi = sh_q[WORD_W-1];

    // R2
    sclk_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!half_end && !load) |=> $stable(sclk));

    // R1
    mosi_setup_chk: assert property (@(posedge clk) disable iff (rst)
        sclk |-> $stable(mosi));

endmodule

// File: rtl/burst_cmd_spi.sv
module burst_cmd_spi #(
    parameter int unsigned WORD_W  = 16,
    parameter int unsigned DEPTH   = 256,
    parameter int unsigned DIV_W   = 8,
    parameter int unsigned PER_W   = 16,
    parameter int unsigned MIN_GAP = 2,
    localparam int unsigned AW     = $clog2(DEPTH),
    localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              start,
    input  logic [CNT_W-1:0]  word_count,
    input  logic [PER_W-1:0]  period,
    input  logic [DIV_W-1:0]  clk_div,
    output logic              sclk,
    output logic              mosi,
    output logic              cs_n,
    output logic              busy,
    output logic              done,
    output logic              period_err
);

    import bcs_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] last_idx;
        logic [PER_W-1:0] span;
        logic [DIV_W-1:0] half;
    } burst_cfg_t;

    seq_state_e        state_q;
    burst_cfg_t        cfg_q;
    burst_cfg_t        cfg_new;
    logic [CNT_W-1:0]  widx_q;
    logic              cs_n_q;
    logic              busy_q;
    logic              done_q;
    logic              err_q;

    logic [CNT_W-1:0]  req_cnt;
    logic [PER_W-1:0]  floor_span;
    logic              too_short;
    logic              accept;
    logic              due;
    logic              frame_start;
    logic              frame_end;
    logic [PER_W-1:0]  elapsed;
    logic [AW-1:0]     rd_addr;
    logic [WORD_W-1:0] rd_word;
    logic              sclk_w;
    logic              mosi_w;

    // Settings captured at an accepted start
    assign req_cnt    = (word_count > CNT_W'(DEPTH)) ? CNT_W'(DEPTH) : word_count;
    assign floor_span = PER_W'(min_period(u32_t'(clk_div), WORD_W, MIN_GAP));
    assign too_short  = (period < floor_span);

    always_comb begin
        cfg_new.last_idx = req_cnt - 1'b1;
        cfg_new.span     = too_short ? floor_span : period;
        cfg_new.half     = DIV_W'(half_len(u32_t'(clk_div)));
    end

    assign accept      = (state_q == ST_IDLE) && start && !busy_q && (word_count != '0);
    assign frame_start = accept || ((state_q == ST_GAP) && due);
    assign rd_addr     = (state_q == ST_IDLE) ? '0 : AW'(widx_q + 1'b1);

    bcs_word_buf #(
        .WORD_W (WORD_W),
        .DEPTH  (DEPTH)
    ) buf_i (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_word)
    );

    bcs_period_timer #(
        .PER_W (PER_W)
    ) timer_i (
        .clk     (clk),
        .rst     (rst),
        .run     (busy_q),
        .restart (frame_start),
        .span    (cfg_q.span),
        .due     (due),
        .elapsed (elapsed)
    );

    bcs_bit_shifter #(
        .WORD_W (WORD_W),
        .DIV_W  (DIV_W)
    ) shift_i (
        .clk       (clk),
        .rst       (rst),
        .load      (frame_start),
        .word      (rd_word),
        .half      (cfg_q.half),
        .sclk      (sclk_w),
        .mosi      (mosi_w),
        .frame_end (frame_end)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
            widx_q  <= '0;
            cs_n_q  <= 1'b1;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        cfg_q   <= cfg_new;
                        err_q   <= too_short;
                        widx_q  <= '0;
                        busy_q  <= 1'b1;
                        cs_n_q  <= 1'b0;
                        state_q <= ST_FRAME;
                    end
                end
                ST_FRAME: begin
                    if (frame_end) begin
                        cs_n_q <= 1'b1;
                        if (widx_q == cfg_q.last_idx) begin
                            busy_q  <= 1'b0;
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            state_q <= ST_GAP;
                        end
                    end
                end
                ST_GAP: begin
                    if (due) begin
                        cs_n_q  <= 1'b0;
                        widx_q  <= widx_q + 1'b1;
                        state_q <= ST_FRAME;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign sclk       = sclk_w;
    assign mosi       = mosi_w;
    assign cs_n       = cs_n_q;
    assign busy       = busy_q;
    assign done       = done_q;
    assign period_err = err_q;

    // R3
    idle_cs_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> cs_n_q);

    // R3
    sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n_q |-> !sclk_w);

    // R4
    frame_align_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n_q) |-> (elapsed == '0));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R7
    done_release_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (cs_n_q && !busy_q));

    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy_q |=> $stable(cfg_q));

    // R5
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy_q |=> $stable(err_q));

endmodule

// File: tb/burst_cmd_spi_tb_top.sv
module burst_cmd_spi_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WORD_W     = 16;
    localparam int DEPTH      = 256;
    localparam int DIV_W      = 8;
    localparam int PER_W      = 16;
    localparam int MIN_GAP    = 2;
    localparam int AW         = 8;
    localparam int CNT_W      = 9;

    localparam int VN = 5;
    localparam int V_CNT [VN] = '{3, 4, 2, 5, 140};
    localparam int V_PER [VN] = '{40, 10, 200, 0, 150};
    localparam int V_DIV [VN] = '{1, 1, 3, 0, 2};

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [AW-1:0]     wr_addr = '0;
    logic [WORD_W-1:0] wr_data = '0;
    logic              start = 1'b0;
    logic [CNT_W-1:0]  word_count = '0;
    logic [PER_W-1:0]  period = '0;
    logic [DIV_W-1:0]  clk_div = '0;
    logic              sclk, mosi, cs_n, busy, done, period_err;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    burst_cmd_spi dut_i (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .start      (start),
        .word_count (word_count),
        .period     (period),
        .clk_div    (clk_div),
        .sclk       (sclk),
        .mosi       (mosi),
        .cs_n       (cs_n),
        .busy       (busy),
        .done       (done),
        .period_err (period_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] pat(input int i, input int seed);
        return 16'((i * 40503 + seed * 7919 + 4660) ^ (i << 5));
    endfunction

    task automatic load_words(input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_en   = 1'b1;
            wr_addr = AW'(i);
            wr_data = pat(i, seed);
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_burst(input int n_req, input int per, input int div,
                             input int seed, input int poke_cycle);
        int  n, h, fl, eff, c, frames, fall_c, bits, limit;
        bit  experr, prev_cs, prev_sclk, edge_bad, busy_bad, sclk_bad, finished;
        logic [15:0] word;
        n      = (n_req > DEPTH) ? DEPTH : n_req;
        h      = (div == 0) ? 1 : div;
        fl     = 2 * WORD_W * h + MIN_GAP;
        eff    = (per < fl) ? fl : per;
        experr = (per < fl);
        load_words(n, seed);
        @(negedge clk);
        word_count = CNT_W'(n_req);
        period     = PER_W'(per);
        clk_div    = DIV_W'(div);
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        c = 0; frames = 0; fall_c = 0; bits = 0; word = '0;
        prev_cs = 1'b1; prev_sclk = 1'b0; edge_bad = 1'b0;
        busy_bad = 1'b0; sclk_bad = 1'b0; finished = 1'b0;
        limit = n * eff + 200;
        while (!finished && c < limit) begin
            if (c == 0) begin
                check(busy == 1'b1, "R7", "busy after start", int'(busy), 1);
                check(period_err == experr, "R5", "period_err", int'(period_err), int'(experr));
            end
            if (!cs_n && prev_cs) begin
                check(c == frames * eff, "R4", "frame fall cycle", c, frames * eff);
                fall_c = c; bits = 0; word = '0; edge_bad = 1'b0;
            end
            if (!cs_n && sclk && !prev_sclk) begin
                if (c - fall_c != (2 * bits + 1) * h) edge_bad = 1'b1;
                word = {word[14:0], mosi};
                bits++;
            end
            if (cs_n && !prev_cs) begin
                check(c - fall_c == 2 * WORD_W * h, "R2", "frame length", c - fall_c, 2 * WORD_W * h);
                check(!edge_bad, "R2", "rising edge timing", int'(edge_bad), 0);
                check(word == pat(frames, seed) && bits == 16, "R1 R6", "word",
                      int'(word), int'(pat(frames, seed)));
                frames++;
            end
            if (cs_n && sclk) sclk_bad = 1'b1;
            if (done) begin
                check(c == (n - 1) * eff + 2 * WORD_W * h, "R7", "done cycle", c,
                      (n - 1) * eff + 2 * WORD_W * h);
                check(!busy, "R7", "busy at done", int'(busy), 0);
                check(frames == n, "R6 R8", "frame count", frames, n);
                finished = 1'b1;
            end else if (!busy) begin
                busy_bad = 1'b1;
            end
            if (poke_cycle > 0 && c == poke_cycle) begin
                start      = 1'b1;
                word_count = CNT_W'(3);
                period     = PER_W'(5);
                clk_div    = DIV_W'(7);
            end
            if (poke_cycle > 0 && c == poke_cycle + 1) start = 1'b0;
            prev_cs   = cs_n;
            prev_sclk = sclk;
            @(negedge clk);
            c++;
        end
        check(finished, "R7", "burst completed", int'(finished), 1);
        check(!busy_bad, "R7", "busy held until done", int'(busy_bad), 0);
        check(!sclk_bad, "R3", "sclk low while cs_n high", int'(sclk_bad), 0);
        check(!done, "R7", "done one cycle", int'(done), 0);
        check(cs_n, "R3", "cs_n high after burst", int'(cs_n), 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check(cs_n == 1'b1, "R9", "cs_n", int'(cs_n), 1);
        check(sclk == 1'b0, "R9", "sclk", int'(sclk), 0);
        check(mosi == 1'b0, "R9", "mosi", int'(mosi), 0);
        check(busy == 1'b0, "R9", "busy", int'(busy), 0);
        check(done == 1'b0, "R9", "done", int'(done), 0);
        check(period_err == 1'b0, "R9", "period_err", int'(period_err), 0);

        for (int v = 0; v < VN; v++) begin
            run_burst(V_CNT[v], V_PER[v], V_DIV[v], v + 1, 0);
        end

        // R6: count of zero starts nothing
        begin
            bit moved;
            moved = 1'b0;
            @(negedge clk);
            word_count = '0;
            period     = PER_W'(50);
            clk_div    = DIV_W'(1);
            start      = 1'b1;
            @(negedge clk);
            start = 1'b0;
            for (int k = 0; k < 6; k++) begin
                if (busy || !cs_n) moved = 1'b1;
                @(negedge clk);
            end
            check(!moved, "R6", "zero count ignored", int'(moved), 0);
        end

        // R8: start while busy must not disturb the burst
        run_burst(6, 60, 1, 11, 20);

        // R6 clamp to depth, R5 period exactly at the minimum
        run_burst(300, 34, 1, 17, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule